// File: doc/BRIEF.md
# Masked Wide-OR Monitoring Fault Detector

This block watches a vector of supply-fault and logic status inputs while a power sequencer holds a steady state. For every input it compares the current level with an expected level, and it reports a fault whenever an input that is being watched sits at the wrong level. Each input has its own one-bit detector with two controls. The watch enable decides whether the input is monitored at all. The expected-level setting gives the polarity that counts as healthy. The per-input results are combined by a wide OR into a single fault flag.

The fault path has no programmable delay. It is registered once, so a deviation reaches the flag on the next clock edge and the sequencer can react at once. The surrounding sequencer reloads the per-state watch and expected-level vectors when it enters a new state, and it signals the end of that reload with a one-cycle pulse. Detection is then held off for a fixed settle count of clocks, so that a partly updated configuration cannot raise a false trip. The block does not choose the next state and does not perform the reload.

Top module: `mon_fault_detector`

## Requirements
- R1: Outside a settle window, fault_vec_o bit i on the clock edge after cycle t equals watch_en_i[i] & (status_i[i] ^ expect_i[i]) as sampled in cycle t. expect_i[i]=1 means high is healthy and expect_i[i]=0 means low is healthy.
- R2: An input whose watch_en_i bit is 0 never sets its fault_vec_o bit, whatever its status and expected level.
- R3: fault_o is 1 exactly when at least one bit of fault_vec_o is 1, in the same cycle.
- R4: A deviation applied in a cycle does not show on the outputs before the next rising clock edge, and it shows right after that edge, with no further delay.
- R5: While rst_n is 0 both outputs are 0, and reset cancels any settle window in progress.
- R6: A cfg_done_i pulse in cycle t clears both outputs for the edges that follow cycle t and the next SETTLE_CYCLES cycles (SETTLE_CYCLES+1 edges in all), whatever the inputs are.
- R7: A cfg_done_i pulse that arrives inside a settle window starts a full window again from that pulse.
- R8: In the first cycle after a settle window ends, detection follows R1 again with no extra delay.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| status_i | input | N_INPUTS | Supply-fault and logic status levels |
| watch_en_i | input | N_INPUTS | Per-input watch enable, 1 = monitored |
| expect_i | input | N_INPUTS | Per-input healthy level |
| cfg_done_i | input | 1 | One-cycle pulse: state configuration reload complete |
| fault_o | output | 1 | Combined fault flag (wide OR) |
| fault_vec_o | output | N_INPUTS | Per-input fault flags |

## Verification
The assertions check on every clock several relations. The combined flag always matches the OR of the vector. A disabled input never reports. A cleared output follows every reload pulse and every window cycle. Outside a window, the vector tracks the one-cycle-old comparison of status, enable and expected level. The bench scenarios show the properties that need a timeline. These are the exact length of the settle window, the restart of a window by a second pulse, the first cycle after a window, the absence of any output change before the edge, and the cancellation of a window by a mid-run reset.

// File: rtl/mon_pkg.sv
package mon_pkg;

  // One-bit deviation test: a watched input that differs from its healthy level.
  function automatic logic bit_deviates(input logic watch, input logic level,
                                        input logic healthy);
    return watch & (level ^ healthy);
  endfunction

endpackage

// File: rtl/mon_bit_det.sv
module mon_bit_det
  import mon_pkg::*;
(
  input  logic level_i,
  input  logic watch_i,
  input  logic healthy_i,
  output logic dev_o
);

  always_comb begin
    dev_o = bit_deviates(watch_i, level_i, healthy_i);
  end

endmodule

// File: rtl/mon_settle_gate.sv
module mon_settle_gate #(
  parameter int unsigned SETTLE_CYCLES = 4,
  localparam int unsigned CNT_W = $clog2(SETTLE_CYCLES + 2)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_done_i,
  output logic blocked_o
);

  localparam logic [CNT_W-1:0] WINDOW_LEN = CNT_W'(SETTLE_CYCLES);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;
  logic             running;

  always_comb begin
    running = (cnt_q != '0);
    cnt_en  = load_done_i | running;
    cnt_d   = cnt_q;
    if (load_done_i) begin
      cnt_d = WINDOW_LEN;
    end else if (running) begin
      cnt_d = cnt_q - CNT_W'(1);
    end
    blocked_o = load_done_i | running;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/mon_or_reduce.sv
module mon_or_reduce #(
  parameter int unsigned WIDTH = 8
) (
  input  logic [WIDTH-1:0] vec_i,
  output logic             any_o
);

  logic [WIDTH:0] chain;

  assign chain[0] = 1'b0;

  for (genvar g = 0; g < WIDTH; g++) begin : g_or
    assign chain[g+1] = chain[g] | vec_i[g];
  end

  assign any_o = chain[WIDTH];

endmodule

// File: rtl/mon_fault_detector.sv
module mon_fault_detector #(
  parameter int unsigned N_INPUTS      = 8,
  parameter int unsigned SETTLE_CYCLES = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [N_INPUTS-1:0] status_i,
  input  logic [N_INPUTS-1:0] watch_en_i,
  input  logic [N_INPUTS-1:0] expect_i,
  input  logic                cfg_done_i,
  output logic                fault_o,
  output logic [N_INPUTS-1:0] fault_vec_o
);

  logic [N_INPUTS-1:0] dev_raw;
  logic [N_INPUTS-1:0] vec_d;
  logic [N_INPUTS-1:0] vec_q;
  logic                any_d;
  logic                any_q;
  logic                blocked;

  for (genvar g = 0; g < N_INPUTS; g++) begin : g_det
    mon_bit_det u_bit (
      .level_i   (status_i[g]),
      .watch_i   (watch_en_i[g]),
      .healthy_i (expect_i[g]),
      .dev_o     (dev_raw[g])
    );
  end

  mon_settle_gate #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_gate (
    .clk         (clk),
    .rst_n       (rst_n),
    .load_done_i (cfg_done_i),
    .blocked_o   (blocked)
  );

  always_comb begin
    vec_d = blocked ? '0 : dev_raw;
  end

  mon_or_reduce #(.WIDTH(N_INPUTS)) u_or (
    .vec_i (vec_d),
    .any_o (any_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vec_q <= '0;
      any_q <= 1'b0;
    end else begin
      vec_q <= vec_d;
      any_q <= any_d;
    end
  end

  assign fault_vec_o = vec_q;
  assign fault_o     = any_q;

endmodule

// File: rtl/mon_fault_detector_chk.sv
module mon_fault_detector_chk #(
  parameter int unsigned N_INPUTS      = 8,
  parameter int unsigned SETTLE_CYCLES = 4
) (
  input logic                clk,
  input logic                rst_n,
  input logic [N_INPUTS-1:0] status_i,
  input logic [N_INPUTS-1:0] watch_en_i,
  input logic [N_INPUTS-1:0] expect_i,
  input logic                cfg_done_i,
  input logic                fault_o,
  input logic [N_INPUTS-1:0] fault_vec_o
);

  localparam int unsigned WW = $clog2(SETTLE_CYCLES + 2);

  logic [WW-1:0] win_q;
  logic          started_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q     <= '0;
      started_q <= 1'b0;
    end else begin
      started_q <= 1'b1;
      if (cfg_done_i) begin
        win_q <= WW'(SETTLE_CYCLES);
      end else if (win_q != '0) begin
        win_q <= win_q - WW'(1);
      end
    end
  end

  // R5: outputs held clear during reset
  assert_reset_clear_R5: assert property (@(posedge clk)
    !rst_n |-> (fault_vec_o == '0 && !fault_o));

  // R3: combined flag equals the OR of the vector
  assert_or_match_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fault_o == (|fault_vec_o));

  // R2: an input not watched in the previous cycle cannot report now
  assert_masked_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    started_q |-> ((fault_vec_o & ~$past(watch_en_i)) == '0));

  // R6: a reload pulse clears the outputs on the next edge
  assert_load_block_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_done_i |=> (fault_vec_o == '0));

  // R7: every cycle of a running window keeps the outputs clear
  assert_window_block_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (win_q != '0) |=> (fault_vec_o == '0));

  // R1: outside a window the vector follows the one-cycle-old comparison
  assert_track_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_done_i && win_q == '0) |=>
      (fault_vec_o == $past(watch_en_i & (status_i ^ expect_i))));

endmodule

bind mon_fault_detector mon_fault_detector_chk #(
  .N_INPUTS      (N_INPUTS),
  .SETTLE_CYCLES (SETTLE_CYCLES)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .status_i    (status_i),
  .watch_en_i  (watch_en_i),
  .expect_i    (expect_i),
  .cfg_done_i  (cfg_done_i),
  .fault_o     (fault_o),
  .fault_vec_o (fault_vec_o)
);

// File: tb/mon_fault_detector_test.sv
module mon_fault_detector_test;

  localparam int N      = 8;
  localparam int SETTLE = 4;

  logic         clk;
  logic         rst_n;
  logic [N-1:0] status_i;
  logic [N-1:0] watch_en_i;
  logic [N-1:0] expect_i;
  logic         cfg_done_i;
  logic         fault_o;
  logic [N-1:0] fault_vec_o;

  int checks;
  int failures;
  int mcnt;
  int cycles;
  bit done;

  mon_fault_detector #(.N_INPUTS(N), .SETTLE_CYCLES(SETTLE)) uut (
    .clk         (clk),
    .rst_n       (rst_n),
    .status_i    (status_i),
    .watch_en_i  (watch_en_i),
    .expect_i    (expect_i),
    .cfg_done_i  (cfg_done_i),
    .fault_o     (fault_o),
    .fault_vec_o (fault_vec_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [N-1:0] ref_dev(input logic [N-1:0] st,
                                           input logic [N-1:0] wt,
                                           input logic [N-1:0] ex);
    return wt & (st ^ ex);
  endfunction

  task automatic check_out(input string tag, input logic [N-1:0] exp_vec);
    checks++;
    if (fault_vec_o !== exp_vec || fault_o !== (|exp_vec)) begin
      failures++;
      $display("FAIL %s: vec=%b flag=%b expected vec=%b flag=%b",
               tag, fault_vec_o, fault_o, exp_vec, |exp_vec);
    end
  endtask

  // Drive at a falling edge, pass one rising edge, check at the next falling edge.
  task automatic step(input logic [N-1:0] st, input logic [N-1:0] wt,
                      input logic [N-1:0] ex, input logic ld, input string tag);
    logic [N-1:0] exp_vec;
    logic         blk;
    status_i   = st;
    watch_en_i = wt;
    expect_i   = ex;
    cfg_done_i = ld;
    blk        = ld || (mcnt != 0);
    exp_vec    = blk ? '0 : ref_dev(st, wt, ex);
    if (ld) mcnt = SETTLE;
    else if (mcnt != 0) mcnt--;
    @(posedge clk);
    @(negedge clk);
    check_out(tag, exp_vec);
  endtask

  initial begin
    cycles = 0;
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000 && !done) begin
        failures++;
        $display("FAIL watchdog: cycles=%0d expected completion", cycles);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  initial begin
    logic [N-1:0] st, wt, ex;
    logic         ld;
    checks = 0; failures = 0; mcnt = 0; done = 0;
    void'($urandom(32'd1357));
    rst_n = 1'b0; cfg_done_i = 1'b0;
    status_i = '1; watch_en_i = '1; expect_i = '0;
    repeat (3) @(negedge clk);
    check_out("R5 reset clears outputs", '0);
    rst_n = 1'b1;

    // R2: all inputs wrong, none watched
    step(8'hFF, 8'h00, 8'h00, 1'b0, "R2 all masked");
    step(8'h5A, 8'h00, 8'hA5, 1'b0, "R2 masked mixed");
    // R1: both polarities of expected level
    step(8'h0F, 8'hFF, 8'hFF, 1'b0, "R1 expect high");
    step(8'h0F, 8'hFF, 8'h00, 1'b0, "R1 expect low");
    step(8'h00, 8'h80, 8'h80, 1'b0, "R3 single top bit");
    step(8'h01, 8'hFF, 8'h01, 1'b0, "R3 all healthy");

    // R4: no change before the edge, change right after it
    status_i = 8'h10; watch_en_i = 8'h10; expect_i = 8'h00; cfg_done_i = 1'b0;
    #9;
    check_out("R4 before edge", '0);
    @(negedge clk);
    check_out("R4 after edge", 8'h10);

    // R6 window with faulty inputs held, then R8 resume
    step(8'hFF, 8'hFF, 8'h00, 1'b1, "R6 load cycle");
    for (int k = 0; k < SETTLE; k++) step(8'hFF, 8'hFF, 8'h00, 1'b0, "R6 window");
    step(8'hC3, 8'hFF, 8'h00, 1'b0, "R8 resume");

    // R7 restart inside a window
    step(8'hFF, 8'hFF, 8'h00, 1'b1, "R7 first load");
    step(8'hFF, 8'hFF, 8'h00, 1'b0, "R7 window");
    step(8'hFF, 8'hFF, 8'h00, 1'b1, "R7 second load");
    for (int k = 0; k < SETTLE; k++) step(8'hFF, 8'hFF, 8'h00, 1'b0, "R7 restarted window");
    step(8'h3C, 8'hFF, 8'h00, 1'b0, "R8 resume after restart");

    // R5: mid-window reset cancels the window
    step(8'hFF, 8'hFF, 8'h00, 1'b1, "R6 load before reset");
    #3 rst_n = 1'b0;
    #2 check_out("R5 async clear", '0);
    mcnt = 0;
    @(negedge clk);
    rst_n = 1'b1;
    step(8'h81, 8'hFF, 8'h00, 1'b0, "R5 window cancelled");

    // Random traffic with occasional reloads
    for (int n = 0; n < 400; n++) begin
      st = N'($urandom); wt = N'($urandom); ex = N'($urandom);
      ld = ($urandom % 9) == 0;
      step(st, wt, ex, ld, ld ? "R6 random load" : "R1 random");
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule